// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the decode stage of a processor that has user, supervisor and machine privilege modes and an optional guest virtualization mode. It receives a class code for the instruction being decoded, together with the current privilege mode and a few trap-control bits. From these it decides whether the instruction runs, takes an illegal-instruction trap, or takes a virtual-instruction trap.

The instruction classes it covers are wait-for-interrupt, the no-timeout reservation wait, the supervisor address-translation fence, the two hypervisor fences (guest-virtual and guest-physical), and the hypervisor guest load/store group. Each class combines the control bits, the mode and the virtualization state in its own order of precedence.

When a wait-for-interrupt is allowed to run, the block also raises a halt request. When any of the three fences is allowed to run, it raises a flush request. The decision is registered, so it appears one clock after the inputs are presented.

Top module: `priv_insn_gate`

## Requirements
- R1: The outputs reflect the inputs sampled at the previous rising clock edge. Exactly one of `exec_o`, `illegal_o` and `virt_trap_o` is high. `cause_o` is 2 with `illegal_o`, 22 with `virt_trap_o`, and 0 otherwise.
- R2: Wait-for-interrupt (class 1) checks are applied in this order:
  - It is illegal when `tw_i` is set and the mode is supervisor.
  - It is illegal when `tw_i` is set, the mode is user and `smode_i` is clear.
  - It is illegal when `smode_i` is set, the mode is user and `virt_i` is clear.
  - Otherwise, with `virt_i` set, it takes a virtual trap in user mode, or in supervisor mode when `vtw_i` is set.
  - Otherwise it executes with `halt_o` high.
- R3: Reservation wait without timeout (class 2) takes a virtual trap when all of these hold: `virt_i` is set, the mode is user or supervisor, `vtw_i` is set and `tw_i` is clear. Otherwise it is illegal when the mode is not machine and `tw_i` is set. Otherwise it executes, with no request.
- R4: Supervisor fence (class 3) checks are applied in this order:
  - With `virt_i` clear, it is illegal in user mode, and in supervisor mode when `tvm_i` is set.
  - With `virt_i` set, it takes a virtual trap in user mode or when `vtvm_i` is set.
  - Otherwise it executes with `flush_o` high.
- R5: Guest-virtual hypervisor fence (class 4) takes a virtual trap whenever `virt_i` is set. Otherwise it executes with `flush_o` high in machine or supervisor mode, and is illegal in user mode.
- R6: Guest-physical hypervisor fence (class 5) is first made illegal when the mode is supervisor, `virt_i` is clear and `tvm_i` is set. Otherwise it follows R5.
- R7: Hypervisor guest load/store (class 6) always executes in machine mode. Otherwise it takes a virtual trap when `virt_i` is set, and is illegal in user mode with `hu_i` clear. Otherwise it executes, with no request.
- R8: Class codes 0 and 7 execute with no trap and no request, whatever the other inputs are.
- R9: While `rst_n` is low, every output is 0.
- R10: Privilege encoding is 0 user, 1 supervisor and 3 machine. The value 2 is treated as machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Instruction class code |
| priv_i | input | 2 | Current privilege mode |
| virt_i | input | 1 | Guest virtualization active |
| smode_i | input | 1 | Supervisor mode implemented |
| tw_i | input | 1 | Trap wait instructions |
| tvm_i | input | 1 | Trap translation management |
| vtw_i | input | 1 | Guest trap wait instructions |
| vtvm_i | input | 1 | Guest trap translation management |
| hu_i | input | 1 | Allow hypervisor load/store in user mode |
| exec_o | output | 1 | Instruction executes |
| illegal_o | output | 1 | Illegal-instruction trap |
| virt_trap_o | output | 1 | Virtual-instruction trap |
| cause_o | output | 5 | Trap cause code |
| halt_o | output | 1 | Halt request |
| flush_o | output | 1 | Translation flush request |

## Verification
The only state in this block is the registered decision. A wrong precedence between checks therefore appears as a wrong trap kind or wrong request one clock after the offending input combination. No other stimulus can mask it. The bench sweeps every combination of class, mode and control bits, which reaches each precedence boundary. The one-cycle latency lets any error be traced to a single input vector.

// File: rtl/priv_insn_gate.sv
module priv_insn_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       smode_i,
  input  logic       tw_i,
  input  logic       tvm_i,
  input  logic       vtw_i,
  input  logic       vtvm_i,
  input  logic       hu_i,
  output logic       exec_o,
  output logic       illegal_o,
  output logic       virt_trap_o,
  output logic [4:0] cause_o,
  output logic       halt_o,
  output logic       flush_o
);
  localparam logic [2:0] OP_WFI  = 3'd1;
  localparam logic [2:0] OP_WRS  = 3'd2;
  localparam logic [2:0] OP_SFN  = 3'd3;
  localparam logic [2:0] OP_HFV  = 3'd4;
  localparam logic [2:0] OP_HFG  = 3'd5;
  localparam logic [2:0] OP_HLS  = 3'd6;
  localparam logic [4:0] CAUSE_ILL  = 5'd2;
  localparam logic [4:0] CAUSE_VIRT = 5'd22;

  logic is_m, is_s, is_u;
  logic n_ok, n_ill, n_vi, n_halt, n_flush;

  assign is_m = priv_i[1];
  assign is_s = (priv_i == 2'b01);
  assign is_u = (priv_i == 2'b00);

  always_comb begin
    n_ok = 1'b0; n_ill = 1'b0; n_vi = 1'b0; n_halt = 1'b0; n_flush = 1'b0;
    case (op_i)
      OP_WFI: begin
        if (((is_s || (!smode_i && is_u)) && tw_i) || (smode_i && is_u && !virt_i))
          n_ill = 1'b1;
        else if (virt_i && (is_u || (is_s && vtw_i)))
          n_vi = 1'b1;
        else begin
          n_ok = 1'b1; n_halt = 1'b1;
        end
      end
      OP_WRS: begin
        if (virt_i && (is_s || is_u) && vtw_i && !tw_i) n_vi = 1'b1;
        else if (!is_m && tw_i)                          n_ill = 1'b1;
        else                                             n_ok = 1'b1;
      end
      OP_SFN: begin
        if (!virt_i && (is_u || (is_s && tvm_i)))  n_ill = 1'b1;
        else if (virt_i && (is_u || vtvm_i))       n_vi = 1'b1;
        else begin
          n_ok = 1'b1; n_flush = 1'b1;
        end
      end
      OP_HFV, OP_HFG: begin
        if (op_i == OP_HFG && is_s && !virt_i && tvm_i) n_ill = 1'b1;
        else if (virt_i)                                n_vi = 1'b1;
        else if (is_m || is_s) begin
          n_ok = 1'b1; n_flush = 1'b1;
        end
        else                                            n_ill = 1'b1;
      end
      OP_HLS: begin
        if (is_m)                   n_ok = 1'b1;
        else if (virt_i)            n_vi = 1'b1;
        else if (is_u && !hu_i)     n_ill = 1'b1;
        else                        n_ok = 1'b1;
      end
      default: n_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_o      <= 1'b0;
      illegal_o   <= 1'b0;
      virt_trap_o <= 1'b0;
      cause_o     <= '0;
      halt_o      <= 1'b0;
      flush_o     <= 1'b0;
    end else begin
      exec_o      <= n_ok;
      illegal_o   <= n_ill;
      virt_trap_o <= n_vi;
      cause_o     <= n_ill ? CAUSE_ILL : (n_vi ? CAUSE_VIRT : 5'd0);
      halt_o      <= n_halt;
      flush_o     <= n_flush;
    end
  end
endmodule

// File: rtl/priv_insn_gate_chk.sv
module priv_insn_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] op_i,
  input logic [1:0] priv_i,
  input logic       virt_i,
  input logic       exec_o,
  input logic       illegal_o,
  input logic       virt_trap_o,
  input logic [4:0] cause_o,
  input logic       halt_o,
  input logic       flush_o
);
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exec_o, illegal_o, virt_trap_o}));
  a_r1_ill_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> cause_o == 5'd2);
  a_r1_virt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    virt_trap_o |-> cause_o == 5'd22);
  a_r2_halt_runs: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (exec_o && $past(op_i) == 3'd1));
  a_r4_flush_runs: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (exec_o && $past(op_i) >= 3'd3 && $past(op_i) <= 3'd5));
  a_r5_virt_needs_guest: assert property (@(posedge clk) disable iff (!rst_n)
    virt_trap_o |-> $past(virt_i));
  a_r7_machine_hls: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd6 && priv_i[1]) |=> exec_o);
  a_r8_other_class: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 || op_i == 3'd7) |=> (exec_o && !halt_o && !flush_o));
endmodule

bind priv_insn_gate priv_insn_gate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .priv_i(priv_i), .virt_i(virt_i),
  .exec_o(exec_o), .illegal_o(illegal_o), .virt_trap_o(virt_trap_o),
  .cause_o(cause_o), .halt_o(halt_o), .flush_o(flush_o)
);

// File: tb/priv_insn_gate_tb_top.sv
module priv_insn_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_i = '0;
  logic [1:0] priv_i = '0;
  logic virt_i = 0, smode_i = 0, tw_i = 0, tvm_i = 0, vtw_i = 0, vtvm_i = 0, hu_i = 0;
  logic exec_o, illegal_o, virt_trap_o, halt_o, flush_o;
  logic [4:0] cause_o;

  int checks = 0;
  int errors = 0;
  logic [9:0] expq[$];
  string tagq[$];

  always #4 clk = ~clk;

  priv_insn_gate dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .priv_i(priv_i), .virt_i(virt_i),
    .smode_i(smode_i), .tw_i(tw_i), .tvm_i(tvm_i), .vtw_i(vtw_i), .vtvm_i(vtvm_i),
    .hu_i(hu_i), .exec_o(exec_o), .illegal_o(illegal_o), .virt_trap_o(virt_trap_o),
    .cause_o(cause_o), .halt_o(halt_o), .flush_o(flush_o)
  );

  // packed expectation: {exec, illegal, virt, halt, flush, cause[4:0]}
  function automatic logic [9:0] model(int op, int pv, bit v, bit sm, bit tw,
                                       bit tvm, bit vtw, bit vtvm, bit hu);
    int res = 0;  // 0 run, 1 illegal, 2 virtual
    bit hlt = 0, fl = 0;
    string mode;
    mode = (pv == 0) ? "U" : (pv == 1) ? "S" : "M";
    if (op == 1) begin
      if (tw && (mode == "S" || (mode == "U" && !sm))) res = 1;
      else if (sm && mode == "U" && !v) res = 1;
      else if (v && (mode == "U" || (mode == "S" && vtw))) res = 2;
      else hlt = 1;
    end else if (op == 2) begin
      if (v && mode != "M" && vtw && !tw) res = 2;
      else if (mode != "M" && tw) res = 1;
    end else if (op == 3) begin
      if (!v) begin
        if (mode == "U" || (mode == "S" && tvm)) res = 1; else fl = 1;
      end else begin
        if (mode == "U" || vtvm) res = 2; else fl = 1;
      end
    end else if (op == 4 || op == 5) begin
      if (op == 5 && mode == "S" && !v && tvm) res = 1;
      else if (v) res = 2;
      else if (mode == "U") res = 1;
      else fl = 1;
    end else if (op == 6) begin
      if (mode == "M") res = 0;
      else if (v) res = 2;
      else if (mode == "U" && !hu) res = 1;
    end
    return {res == 0, res == 1, res == 2, hlt, fl,
            (res == 1) ? 5'd2 : (res == 2) ? 5'd22 : 5'd0};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_out(logic [9:0] exp, string tag);
    logic [9:0] act;
    act = {exec_o, illegal_o, virt_trap_o, halt_o, flush_o, cause_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/R1 actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: outputs held at zero while reset is low, even with live inputs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_i = 3'(k + 1); priv_i = 2'(k); virt_i = k[0]; tw_i = 1'b1;
      @(negedge clk);
      check_out(10'd0, "R9");
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R10 priv 2 treated as machine; full sweep covers it
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      if (expq.size() > 0) check_out(expq.pop_front(), tagq.pop_front());
      op_i = i[11:9]; priv_i = i[8:7]; virt_i = i[6]; smode_i = i[5];
      tw_i = i[4]; tvm_i = i[3]; vtw_i = i[2]; vtvm_i = i[1]; hu_i = i[0];
      expq.push_back(model(int'(i[11:9]), int'(i[8:7]), i[6], i[5], i[4],
                           i[3], i[2], i[1], i[0]));
      tagq.push_back((i[8:7] == 2'd2) ? {tag_of(int'(i[11:9])), "/R10"}
                                       : tag_of(int'(i[11:9])));
    end
    @(negedge clk);
    check_out(expq.pop_front(), tagq.pop_front());
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule